// File: doc/BRIEF.md
# Shift-and-Add Transposed FIR Filter

This block is a finite impulse response filter whose tap weights are fixed when the design is elaborated. It contains no general multiplier. Each tap weight is recoded into signed binary digits taking the values -1, 0 and +1, with no two neighbouring digits both non-zero. The product for that tap is then the sum or difference of constant-shifted copies of the incoming sample. A shift by a constant is only wiring, so each tap costs one adder or subtractor per non-zero digit after the first.

The filter uses the transposed arrangement. Every tap product is formed from the same current sample. The delay registers sit between the adders on the path that runs toward the output, so the longest combinational path is one constant product plus one addition, however many taps there are. The output sequence is the same as that of the textbook delay-line form.

A sample is accepted in each cycle in which the input-valid strobe is high. The matching result appears one clock later with its own valid strobe. The result is wide enough that it can never wrap.

Top module: `fir_csd_transposed`

## Requirements
- R1: For every accepted sample x[n], the output is y[n] = sum over k = 0..NTAPS-1 of h[k]·x[n-k]. Here x[n-k] counts only samples accepted since reset (earlier ones are zero), and h[0] is the lowest-indexed entry of the weight vector.
- R2: Each tap product equals the exact two's-complement product of the sample and that tap weight. It is built only from shifted copies of the sample, added or subtracted according to the weight's signed-digit recoding.
- R3: The output is XW + CW + ceil(log2(NTAPS)) bits wide. It gives the exact result even when every stored sample is at the extreme of its range with the sign that makes the sum largest in magnitude.
- R4: out_valid is high in exactly the cycles that follow a cycle in which in_valid was high and reset was low.
- R5: A cycle with in_valid low leaves out_sample and the filter history unchanged. The results of later samples are as if the idle cycle had never occurred.
- R6: A synchronous reset clears out_valid, out_sample and the whole history. The first result after reset is h[0]·x.
- R7: A unit impulse produces the output sequence h[0], h[1], …, h[NTAPS-1], followed by zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | High when in_sample carries a new sample |
| in_sample | input | XW | Signed two's-complement input sample |
| out_valid | output | 1 | High when out_sample carries a new result |
| out_sample | output | XW+CW+ceil(log2(NTAPS)) | Signed full-precision filter result |

## Verification
Every result is due exactly one clock after the cycle that delivered its sample, and out_valid follows the same one-cycle delay. The bench therefore drives each sample on a falling edge and compares the output on the next falling edge against a direct-form reference that it keeps itself. In an idle cycle the bench instead checks, one clock later, that out_valid is low and out_sample still holds its previous value. A reset is checked on the falling edge after the clock that sampled it, and the first sample after reset is checked on the falling edge after it.

// File: rtl/csd_pkg.sv
package csd_pkg;

    // Non-adjacent signed-digit recoding of v: bit d set in the result
    // means a +2^d digit. Uses t = v + v/2 and the bits where t and v/2 differ.
    function automatic logic [63:0] csd_plus(input longint v);
        longint half;
        longint tri3;
        half = v >>> 1;
        tri3 = v + half;
        return 64'(tri3 & (half ^ tri3));
    endfunction

    // Companion mask: bit d set means a -2^d digit.
    function automatic logic [63:0] csd_minus(input longint v);
        longint half;
        longint tri3;
        half = v >>> 1;
        tri3 = v + half;
        return 64'(half & (half ^ tri3));
    endfunction

endpackage

// File: rtl/csd_const_mult.sv
module csd_const_mult #(
    parameter int            XW   = 12,
    parameter int            CW   = 10,
    parameter logic [CW-1:0] COEF = '0,
    parameter int            OW   = 25
) (
    input  logic signed [XW-1:0] x,
    output logic signed [OW-1:0] p
);
    localparam longint      CVAL  = longint'($signed(COEF));
    localparam int          ND    = CW + 1;
    localparam logic [63:0] PLUS  = csd_pkg::csd_plus(CVAL);
    localparam logic [63:0] MINUS = csd_pkg::csd_minus(CVAL);

    logic signed [OW-1:0] xe;
    logic signed [OW-1:0] partial [ND+1];

    assign xe         = OW'(x);
    assign partial[0] = '0;

    for (genvar d = 0; d < ND; d++) begin : g_digit
        if (PLUS[d]) begin : g_add
            assign partial[d+1] = partial[d] + (xe <<< d);
        end else if (MINUS[d]) begin : g_sub
            assign partial[d+1] = partial[d] - (xe <<< d);
        end else begin : g_pass
            assign partial[d+1] = partial[d];
        end
    end

    assign p = partial[ND];

    // R2: shift-and-add result matches a true product
    always_comb begin
        assert_product_exact_R2: assert (longint'(p) == longint'(x) * CVAL)
            else $error("tap product mismatch");
    end
endmodule

// File: rtl/fir_product_bank.sv
module fir_product_bank #(
    parameter int                       NTAPS = 6,
    parameter int                       XW    = 12,
    parameter int                       CW    = 10,
    parameter logic [NTAPS-1:0][CW-1:0] COEFS = '0,
    parameter int                       OW    = 25
) (
    input  logic signed [XW-1:0]        x,
    output logic [NTAPS-1:0][OW-1:0]    prod
);
    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        logic signed [OW-1:0] pk;
        csd_const_mult #(
            .XW(XW), .CW(CW), .COEF(COEFS[k]), .OW(OW)
        ) u_mult (
            .x(x),
            .p(pk)
        );
        assign prod[k] = pk;
    end
endmodule

// File: rtl/fir_csd_transposed.sv
module fir_csd_transposed #(
    parameter int                       NTAPS = 6,
    parameter int                       XW    = 12,
    parameter int                       CW    = 10,
    parameter logic [NTAPS-1:0][CW-1:0] COEFS = {-10'sd3, 10'sd37, -10'sd200,
                                                 10'sd255, -10'sd113, 10'sd71},
    parameter int                       OW    = XW + CW + $clog2(NTAPS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [XW-1:0] in_sample,
    output logic                 out_valid,
    output logic signed [OW-1:0] out_sample
);
    localparam int NREG = NTAPS - 1;

    typedef struct packed {
        logic [NREG-1:0][OW-1:0] chain;
        logic [OW-1:0]           y;
        logic                    vld;
    } state_t;

    state_t                   st_d, st_q;
    logic [NTAPS-1:0][OW-1:0] prod;

    fir_product_bank #(
        .NTAPS(NTAPS), .XW(XW), .CW(CW), .COEFS(COEFS), .OW(OW)
    ) u_bank (
        .x(in_sample),
        .prod(prod)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.y = prod[0] + st_q.chain[0];
            for (int k = 0; k < NREG - 1; k++) begin
                st_d.chain[k] = prod[k+1] + st_q.chain[k+1];
            end
            st_d.chain[NREG-1] = prod[NTAPS-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid  = st_q.vld;
    assign out_sample = st_q.y;

    // R4: output strobe trails the input strobe by one clock
    assert_valid_delay_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_valid == $past(in_valid)))
        else $error("out_valid not aligned");

    // R5: idle cycle keeps result and history
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_sample) && $stable(st_q.chain)))
        else $error("state changed while idle");

    // R6: reset clears the outputs
    assert_reset_clear_R6: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0))
        else $error("reset did not clear");
endmodule

// File: tb/fir_csd_transposed_bench.sv
module fir_csd_transposed_bench;
    localparam int NT = 6;
    localparam int XW = 12;
    localparam int CW = 10;
    localparam int OW = XW + CW + $clog2(NT);
    localparam int H [NT] = '{71, -113, 255, -200, 37, -3};
    localparam logic [NT-1:0][CW-1:0] COEFS = {-10'sd3, 10'sd37, -10'sd200,
                                               10'sd255, -10'sd113, 10'sd71};

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [XW-1:0] in_sample = '0;
    logic                 out_valid;
    logic signed [OW-1:0] out_sample;

    longint hist [NT];
    int     n_chk  = 0;
    int     n_fail = 0;
    bit     done   = 1'b0;

    fir_csd_transposed #(
        .NTAPS(NT), .XW(XW), .CW(CW), .COEFS(COEFS)
    ) u_fir_csd_transposed (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    always #5 clk = ~clk;

    function automatic longint model();
        longint s = 0;
        for (int k = 0; k < NT; k++) s += longint'(H[k]) * hist[k];
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_hist();
        for (int k = 0; k < NT; k++) hist[k] = 0;
    endtask

    // Drive on a falling edge, compare one clock later on the next falling edge.
    task automatic step(input bit v, input longint xv, input string req);
        longint prev;
        longint exp;
        in_valid  = v;
        in_sample = XW'(xv);
        prev      = longint'(out_sample);
        @(negedge clk);
        if (v) begin
            for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = longint'($signed(XW'(xv)));
            exp = model();
            check(out_valid == 1'b1, {req, " valid"}, longint'(out_valid), 1);
            check(longint'(out_sample) == exp, req, longint'(out_sample), exp);
        end else begin
            check(out_valid == 1'b0, "R4 idle valid", longint'(out_valid), 0);
            check(longint'(out_sample) == prev, "R5 hold", longint'(out_sample), prev);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        clear_hist();
        repeat (3) @(negedge clk);
        // R6: reset state
        check(out_valid == 1'b0, "R6 reset valid", longint'(out_valid), 0);
        check(out_sample == '0, "R6 reset sample", longint'(out_sample), 0);
        rst = 1'b0;

        // R7: unit impulse returns the weights in order, then zeros
        step(1'b1, 1, "R7");
        for (int i = 0; i < NT + 2; i++) step(1'b1, 0, "R7");

        // R2: scaled impulses at the input extremes
        step(1'b1, -2048, "R2");
        for (int i = 0; i < NT; i++) step(1'b1, 0, "R2");
        step(1'b1, 2047, "R2");
        for (int i = 0; i < NT; i++) step(1'b1, 0, "R2");

        // R3: worst-case magnitude, both signs
        for (int j = 0; j < NT; j++) step(1'b1, (H[NT-1-j] >= 0) ? -2048 : 2047, "R3");
        for (int j = 0; j < NT; j++) step(1'b1, (H[NT-1-j] >= 0) ? -2048 : -2048 + 1, "R3");
        for (int j = 0; j < NT; j++) step(1'b1, (H[NT-1-j] >= 0) ? 2047 : -2048, "R3");

        // R5: impulse interleaved with idle cycles
        step(1'b1, 5, "R5");
        step(1'b0, 0, "R5");
        step(1'b0, 0, "R5");
        step(1'b1, -7, "R5");
        step(1'b0, 0, "R5");
        step(1'b1, 0, "R5");

        // R1: random samples with random gaps
        for (int i = 0; i < 600; i++) begin
            bit     v  = ($urandom % 4) != 0;
            longint xv = longint'($signed(XW'($urandom)));
            step(v, xv, v ? "R1" : "R5");
        end

        // R6: reset in the middle of a stream
        in_valid  = 1'b1;
        in_sample = 12'sd500;
        rst       = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R6 mid valid", longint'(out_valid), 0);
        check(out_sample == '0, "R6 mid sample", longint'(out_sample), 0);
        rst = 1'b0;
        clear_hist();
        step(1'b1, 300, "R6");
        step(1'b1, -1, "R6");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule